// File: doc/BRIEF.md
# Calendar Real-Time Clock with Register Access

This peripheral holds a calendar time and moves it forward by one second on each pulse of a once-per-second tick. The time is made of century, two-digit year, month, day, hour, minute and second. A small 32-bit register bus reaches it through byte addresses, and the word index is the address shifted right by two. Two packed time words carry the calendar fields and a control word holds two bits. One bit starts and stops counting. The other bit must be set before software may load a new time.

Software normally sets the unlock bit and writes both time words. It then writes control with the enable bit set and the unlock bit cleared. From then on the clock counts through every calendar boundary, including leap days under the Gregorian century rule. The alarm word, the alarm-status word and unmapped offsets are decoded. They read as zero and writes to them do nothing.

Top module: `cal_rtc`

## Requirements
- R1: After reset the control word and both time words read as 0, so the clock starts disabled and locked.
- R2: Time word 0 (byte offset 0x00) holds the second in bits [5:0], the minute in bits [13:8], the hour in bits [20:16] and the day of month in bits [28:24].
- R3: Time word 1 (byte offset 0x04) holds the month (1 to 12) in bits [3:0], the year within the century in bits [14:8] and the century in bits [20:16].
- R4: The control word sits at byte offset 0x10. Bit 0 enables counting and bit 1 unlocks the time words. A write to control is always taken and leaves the time unchanged. Its other bits read as 0.
- R5: A write to either time word is dropped while the unlock bit is 0.
- R6: While enable is 1, each single-cycle pulse on `tick_1hz` advances the time by one second. While enable is 0 the time words keep their value.
- R7: The second wraps from 59 to 0 and carries into the minute. The minute wraps from 59 to 0 and carries into the hour. The hour wraps from 23 to 0 and carries into the day.
- R8: The day wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, and 31 for the other months. February has 28 days, or 29 in a leap year. A year is a leap year when it is divisible by 4, except that year 00 of a century is a leap year only when the century is divisible by 4.
- R9: The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0 and increments the century.
- R10: When a bus write and a tick fall in the same cycle, the write takes effect and that tick is discarded.
- R11: The alarm word (0x08), the alarm-status word (0x14) and every unmapped offset read as 0. Writes to them change no register.
- R12: Bits outside the defined fields of the time words read as 0, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read, valid while `bus_sel` is high |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr`; 0 when `bus_sel` is low |
| tick_1hz | input | 1 | Single-cycle pulse once per second |

## Verification
The assertions assume several things about the inputs. Reset is high from time zero. The bus inputs are steady across each rising edge. A tick lasts exactly one cycle, so one step per accepted tick is the correct expectation. The bench changes every input on the falling edge and holds reset for several cycles. It raises `tick_1hz` for a single cycle at a time. The only case where it overlaps a tick with a bus write is the deliberate collision that R10 covers.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 7;
    localparam int CENT_W = 5;

    // word indices (byte address >> 2)
    localparam int IDX_TIME_LO = 0;
    localparam int IDX_TIME_HI = 1;
    localparam int IDX_CTRL    = 4;

    typedef struct packed {
        logic [CENT_W-1:0] cent;
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_time_t;

    typedef struct packed {
        logic unlock;
        logic enable;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_LO,
        SEL_HI,
        SEL_CTRL,
        SEL_ZERO
    } reg_sel_e;

    function automatic logic [31:0] pack_lo(cal_time_t t);
        return {3'b0, t.day, 3'b0, t.hour, 2'b0, t.min, 2'b0, t.sec};
    endfunction

    function automatic logic [31:0] pack_hi(cal_time_t t);
        return {11'b0, t.cent, 1'b0, t.year, 4'b0, t.mon};
    endfunction

    function automatic cal_time_t unpack_lo(cal_time_t t, logic [31:0] w);
        cal_time_t r;
        r      = t;
        r.day  = w[28:24];
        r.hour = w[20:16];
        r.min  = w[13:8];
        r.sec  = w[5:0];
        return r;
    endfunction

    function automatic cal_time_t unpack_hi(cal_time_t t, logic [31:0] w);
        cal_time_t r;
        r      = t;
        r.cent = w[20:16];
        r.year = w[14:8];
        r.mon  = w[3:0];
        return r;
    endfunction

    // year 00 of a century: the full year is cent*100, and 100 = 0 mod 4,
    // so divisibility by 400 reduces to the century being a multiple of 4
    function automatic logic is_leap(logic [CENT_W-1:0] cent, logic [YEAR_W-1:0] year);
        if (year == '0)
            return cent[1:0] == 2'b00;
        return year[1:0] == 2'b00;
    endfunction

    function automatic logic [DAY_W-1:0] month_days(logic [MON_W-1:0] mon, logic leap);
        case (mon)
            4'd2:                      return leap ? DAY_W'(29) : DAY_W'(28);
            4'd4, 4'd6, 4'd9, 4'd11:   return DAY_W'(30);
            default:                   return DAY_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/cal_rtc_decode.sv
module cal_rtc_decode
    import cal_rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:2];

    always_comb begin
        if (idx == IDX_W'(IDX_TIME_LO))
            sel = SEL_LO;
        else if (idx == IDX_W'(IDX_TIME_HI))
            sel = SEL_HI;
        else if (idx == IDX_W'(IDX_CTRL))
            sel = SEL_CTRL;
        else
            sel = SEL_ZERO;  // alarm, alarm status, gaps, beyond window
    end

    logic unused_lsb;
    assign unused_lsb = ^addr[1:0];
endmodule

// File: rtl/cal_rtc_advance.sv
module cal_rtc_advance
    import cal_rtc_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
    localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
    localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);
    localparam logic [MON_W-1:0]  MON_LAST  = MON_W'(12);
    localparam logic [YEAR_W-1:0] YEAR_LAST = YEAR_W'(99);

    logic [DAY_W-1:0] last_day;
    assign last_day = month_days(cur.mon, is_leap(cur.cent, cur.year));

    // ">=" so that an out-of-range loaded field still wraps
    always_comb begin
        nxt = cur;
        if (cur.sec < SEC_LAST) begin
            nxt.sec = cur.sec + 1'b1;
        end else begin
            nxt.sec = '0;
            if (cur.min < MIN_LAST) begin
                nxt.min = cur.min + 1'b1;
            end else begin
                nxt.min = '0;
                if (cur.hour < HOUR_LAST) begin
                    nxt.hour = cur.hour + 1'b1;
                end else begin
                    nxt.hour = '0;
                    if (cur.day < last_day) begin
                        nxt.day = cur.day + 1'b1;
                    end else begin
                        nxt.day = DAY_W'(1);
                        if (cur.mon < MON_LAST) begin
                            nxt.mon = cur.mon + 1'b1;
                        end else begin
                            nxt.mon = MON_W'(1);
                            if (cur.year < YEAR_LAST) begin
                                nxt.year = cur.year + 1'b1;
                            end else begin
                                nxt.year = '0;
                                nxt.cent = cur.cent + 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cal_rtc_timekeeper.sv
module cal_rtc_timekeeper
    import cal_rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_lo,
    input  logic        load_hi,
    input  logic [31:0] wdata,
    input  logic        step,
    output cal_time_t   now
);
    cal_time_t nxt;

    cal_rtc_advance u_adv (
        .cur (now),
        .nxt (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            now <= '0;
        else if (load_lo)
            now <= unpack_lo(now, wdata);
        else if (load_hi)
            now <= unpack_hi(now, wdata);
        else if (step)
            now <= nxt;
    end
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import cal_rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_1hz
);
    reg_sel_e  sel;
    ctrl_t     ctrl_q;
    cal_time_t now_q;
    logic      wr_cyc;
    logic      load_lo;
    logic      load_hi;
    logic      step;

    cal_rtc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_cyc  = bus_sel & bus_wr;
    assign load_lo = wr_cyc & (sel == SEL_LO) & ctrl_q.unlock;
    assign load_hi = wr_cyc & (sel == SEL_HI) & ctrl_q.unlock;
    // any write cycle swallows a coincident tick
    assign step    = tick_1hz & ctrl_q.enable & ~wr_cyc;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_cyc && sel == SEL_CTRL)
            ctrl_q <= ctrl_t'(bus_wdata[1:0]);
    end

    cal_rtc_timekeeper u_tk (
        .clk     (clk),
        .rst     (rst),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .wdata   (bus_wdata),
        .step    (step),
        .now     (now_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (sel)
                SEL_LO:   bus_rdata = pack_lo(now_q);
                SEL_HI:   bus_rdata = pack_hi(now_q);
                SEL_CTRL: bus_rdata = {30'b0, ctrl_q};
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
    import cal_rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              tick_1hz,
    input ctrl_t             ctrl_q,
    input cal_time_t         now_q
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [31:0] LO_PAD = 32'hE0E0_C0C0;
    localparam logic [31:0] HI_PAD = 32'hFFE0_80F0;

    logic [IDX_W-1:0] idx;
    logic             wr_c;
    logic             is_lo;
    logic             is_time;
    logic             is_ctrl;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign wr_c    = bus_sel & bus_wr;
    assign is_lo   = idx == IDX_W'(IDX_TIME_LO);
    assign is_time = is_lo || idx == IDX_W'(IDX_TIME_HI);
    assign is_ctrl = idx == IDX_W'(IDX_CTRL);

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_c && is_time && !ctrl_q.unlock |=> $stable(now_q));  // R5

    AST_CTRL_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        wr_c && is_ctrl |=> ctrl_q == ctrl_t'($past(bus_wdata[1:0])));  // R4

    AST_CTRL_KEEPS_TIME: assert property (@(posedge clk) disable iff (rst)
        wr_c && is_ctrl |=> $stable(now_q));  // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.enable && !wr_c |=> $stable(now_q));  // R6

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.enable && tick_1hz && !wr_c && now_q.sec < SEC_W'(59)
        |=> now_q.sec == $past(now_q.sec) + 1'b1);  // R6

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.enable && tick_1hz && !wr_c && now_q.sec == SEC_W'(59)
        |=> now_q.sec == '0);  // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_c && is_lo && ctrl_q.unlock |=> now_q.sec == $past(bus_wdata[5:0]));  // R10

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_sel && !is_time && !is_ctrl |-> bus_rdata == '0);  // R11

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_sel && is_time |-> (bus_rdata & (is_lo ? LO_PAD : HI_PAD)) == '0);  // R12
endmodule

bind cal_rtc cal_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_1hz  (tick_1hz),
    .ctrl_q    (ctrl_q),
    .now_q     (now_q)
);

// File: tb/cal_rtc_tb.sv
module cal_rtc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;

    localparam logic [ADDR_W-1:0] A_LO   = 5'h00;
    localparam logic [ADDR_W-1:0] A_HI   = 5'h04;
    localparam logic [ADDR_W-1:0] A_ALM  = 5'h08;
    localparam logic [ADDR_W-1:0] A_GAP  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_CTRL = 5'h10;
    localparam logic [ADDR_W-1:0] A_ALST = 5'h14;
    localparam logic [ADDR_W-1:0] A_OUT1 = 5'h18;
    localparam logic [ADDR_W-1:0] A_OUT2 = 5'h1C;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              tick_1hz = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cal_rtc #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_1hz  (tick_1hz)
    );

    function automatic logic [31:0] mk_lo(int d, int h, int m, int s);
        return (32'(d) << 24) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] mk_hi(int c, int y, int mo);
        return (32'(c) << 16) | (32'(y) << 8) | 32'(mo);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_chk(logic [ADDR_W-1:0] a, string req, string what, logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        chk(req, what, v, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_time(int c, int y, int mo, int d, int h, int m, int s);
        bus_write(A_CTRL, 32'h2);
        bus_write(A_HI, mk_hi(c, y, mo));
        bus_write(A_LO, mk_lo(d, h, m, s));
    endtask

    task automatic t_reset();
        read_chk(A_CTRL, "R1", "ctrl after reset", 32'h0);
        read_chk(A_LO,   "R1", "time lo after reset", 32'h0);
        read_chk(A_HI,   "R1", "time hi after reset", 32'h0);
    endtask

    task automatic t_lock();
        bus_write(A_LO, mk_lo(3, 4, 5, 6));
        bus_write(A_HI, mk_hi(20, 1, 2));
        read_chk(A_LO, "R5", "locked lo write dropped", 32'h0);
        read_chk(A_HI, "R5", "locked hi write dropped", 32'h0);
    endtask

    task automatic t_ctrl_bits();
        bus_write(A_CTRL, 32'hFFFF_FFFC);
        read_chk(A_CTRL, "R4", "ctrl high bits ignored", 32'h0);
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        read_chk(A_CTRL, "R4", "ctrl both bits set", 32'h3);
        bus_write(A_CTRL, 32'h0);
    endtask

    task automatic t_layout();
        bus_write(A_CTRL, 32'h2);
        read_chk(A_CTRL, "R4", "unlock bit reads back", 32'h2);
        bus_write(A_LO, mk_lo(15, 10, 20, 30) | 32'hE0E0_C0C0);
        read_chk(A_LO, "R2", "lo field layout", mk_lo(15, 10, 20, 30));
        bus_write(A_HI, mk_hi(20, 24, 6) | 32'hFFE0_8070);
        read_chk(A_HI, "R3", "hi field layout", mk_hi(20, 24, 6));
        read_chk(A_LO, "R12", "lo pad bits zero", 32'h0F0A_141E);
    endtask

    task automatic t_count();
        pulse_tick();
        read_chk(A_LO, "R6", "disabled tick ignored", mk_lo(15, 10, 20, 30));
        bus_write(A_CTRL, 32'h3);
        read_chk(A_LO, "R4", "ctrl write keeps time", mk_lo(15, 10, 20, 30));
        pulse_tick();
        read_chk(A_LO, "R6", "one tick", mk_lo(15, 10, 20, 31));
        pulse_tick();
        pulse_tick();
        read_chk(A_LO, "R6", "three ticks", mk_lo(15, 10, 20, 33));
        bus_write(A_CTRL, 32'h1);
        bus_write(A_LO, mk_lo(1, 1, 1, 1));
        read_chk(A_LO, "R5", "relocked write dropped", mk_lo(15, 10, 20, 33));
        pulse_tick();
        read_chk(A_LO, "R6", "counts while locked", mk_lo(15, 10, 20, 34));
        read_chk(A_HI, "R6", "hi unchanged", mk_hi(20, 24, 6));
    endtask

    task automatic t_roll();
        set_time(20, 23, 6, 10, 10, 59, 59);
        bus_write(A_CTRL, 32'h1);
        pulse_tick();
        read_chk(A_LO, "R7", "minute carry into hour", mk_lo(10, 11, 0, 0));
        set_time(20, 23, 6, 10, 23, 59, 59);
        bus_write(A_CTRL, 32'h1);
        pulse_tick();
        read_chk(A_LO, "R7", "hour carry into day", mk_lo(11, 0, 0, 0));
        set_time(20, 99, 12, 31, 23, 59, 59);
        bus_write(A_CTRL, 32'h1);
        pulse_tick();
        read_chk(A_LO, "R9", "century roll lo", mk_lo(1, 0, 0, 0));
        read_chk(A_HI, "R9", "century roll hi", mk_hi(21, 0, 1));
        set_time(20, 41, 12, 31, 23, 59, 59);
        bus_write(A_CTRL, 32'h1);
        pulse_tick();
        read_chk(A_HI, "R9", "year carry", mk_hi(20, 42, 1));
    endtask

    task automatic day_case(int c, int y, int mo, int d, int emo, int ed);
        set_time(c, y, mo, d, 23, 59, 59);
        bus_write(A_CTRL, 32'h1);
        pulse_tick();
        read_chk(A_LO, "R8", $sformatf("day after %0d%02d-%0d-%0d", c, y, mo, d), mk_lo(ed, 0, 0, 0));
        read_chk(A_HI, "R8", $sformatf("month after %0d%02d-%0d-%0d", c, y, mo, d), mk_hi(c, y, emo));
    endtask

    task automatic t_months();
        day_case(20, 24, 2, 28, 2, 29);
        day_case(20, 24, 2, 29, 3, 1);
        day_case(20, 23, 2, 28, 3, 1);
        day_case(21, 0, 2, 28, 3, 1);
        day_case(20, 0, 2, 28, 2, 29);
        day_case(20, 23, 4, 30, 5, 1);
        day_case(20, 23, 11, 30, 12, 1);
        day_case(20, 23, 1, 30, 1, 31);
        day_case(20, 23, 1, 31, 2, 1);
    endtask

    task automatic t_priority();
        set_time(20, 23, 3, 3, 3, 3, 3);
        bus_write(A_CTRL, 32'h3);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_LO;
        bus_wdata = mk_lo(5, 6, 7, 8); tick_1hz = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_1hz = 1'b0;
        read_chk(A_LO, "R10", "write beats tick", mk_lo(5, 6, 7, 8));
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CTRL;
        bus_wdata = 32'h3; tick_1hz = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_1hz = 1'b0;
        read_chk(A_LO, "R10", "ctrl write drops tick", mk_lo(5, 6, 7, 8));
        pulse_tick();
        read_chk(A_LO, "R10", "later tick counts", mk_lo(5, 6, 7, 9));
    endtask

    task automatic t_reserved();
        set_time(20, 30, 7, 4, 12, 0, 0);
        bus_write(A_CTRL, 32'h2);
        bus_write(A_ALM,  32'hFFFF_FFFF);
        bus_write(A_ALST, 32'hFFFF_FFFF);
        bus_write(A_GAP,  32'hFFFF_FFFF);
        bus_write(A_OUT1, 32'hFFFF_FFFF);
        bus_write(A_OUT2, 32'hFFFF_FFFF);
        read_chk(A_ALM,  "R11", "alarm reads zero", 32'h0);
        read_chk(A_ALST, "R11", "alarm status reads zero", 32'h0);
        read_chk(A_GAP,  "R11", "gap reads zero", 32'h0);
        read_chk(A_OUT1, "R11", "past window reads zero", 32'h0);
        read_chk(A_LO,   "R11", "lo untouched", mk_lo(4, 12, 0, 0));
        read_chk(A_HI,   "R11", "hi untouched", mk_hi(20, 30, 7));
        read_chk(A_CTRL, "R11", "ctrl untouched", 32'h2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lock();
        t_ctrl_bits();
        t_layout();
        t_count();
        t_roll();
        t_months();
        t_priority();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule